// File: doc/BRIEF.md
# Dual-Scan Passive-Matrix Refresh Controller

This block keeps a passive-matrix display alive. The panel is split into an upper half and a lower half, and each half holds `ROWS` rows of `COLS` dots. The panel has no frame memory, so the block refreshes it without pause, even when the image does not change. A simple upstream stream feeds it. Each accepted beat carries one dot for the upper half and one dot for the lower half.

The block packs every four beats into a nibble for each half. It puts the two nibbles on two separate 4-bit buses and strobes them into the panel with a shared shift clock. When a full row has been shifted, the block pulses a row latch. It then waits a programmable number of rest clocks and starts the next row. A frame-start marker is high for the first row of each frame. An alternation output flips once per frame so that no DC bias builds up on the panel.

The rest count sets the frame period. The parameter `MIN_IDLE` sets a floor on it, so that the frame can never run faster than the panel allows. At a 200 MHz clock with the default geometry, a rest count of 8789 gives a frame of about 11.7 ms. The default floor of 5706 keeps the frame at 8 ms or longer.

Top module: `lcd_dual_scan_ctrl`

## Requirements
- R1: While reset is asserted, both strobes are low, both buses read 0, the frame marker is high, the alternation output is low and ready is high.
- R2: For each half, the first of four accepted beats appears on bus bit 3 and the fourth appears on bit 0. The upper-half dot goes to the upper bus and the lower-half dot goes to the lower bus, on the same strobe.
- R3: The shift clock is high for exactly one clock per nibble. Each row carries exactly COLS/4 shift-clock pulses.
- R4: Both buses hold their value in the clock before the shift clock is high, during it, and in the clock after it falls.
- R5: The row latch is a one-clock pulse. It comes in the clock right after the last shift-clock pulse of a row and never together with the shift clock.
- R6: Ready is high only while the block is gathering beats. A beat with valid low is not consumed. Shifting pauses mid-row, and no strobe is issued while the stream stalls.
- R7: After each row latch, ready stays low for max(idle_cycles, MIN_IDLE) clocks before gathering resumes. The rest count is sampled during the latch clock.
- R8: A frame has ROWS rows. The frame marker is high from the start of row 0 through row 0's latch pulse and low for all other rows.
- R9: The alternation output flips exactly once per frame, in the clock after the last row's latch pulse, and never at any other time.
- R10: Refresh never stops. With the stream always valid, the frame period is ROWS*(6*COLS/4 + 1 + rest) clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| idle_cycles | input | IDLE_W | Rest clocks inserted after each row latch |
| pix_valid | input | 1 | Upstream beat valid |
| pix_upper | input | 1 | Dot for the upper half |
| pix_lower | input | 1 | Dot for the lower half |
| pix_ready | output | 1 | Block accepts a beat this clock |
| lcd_du | output | 4 | Upper-half nibble bus |
| lcd_dl | output | 4 | Lower-half nibble bus |
| lcd_cp2 | output | 1 | Shift clock |
| lcd_cp1 | output | 1 | Row latch pulse |
| lcd_s | output | 1 | Frame-start marker |
| lcd_m | output | 1 | Per-frame alternation signal |

## Verification
A behavioural model built from queues and integers predicts every output on every clock. The stream runs at full rate, with random stalls, and with a long stall, so stalls fall in every position inside a nibble and at row ends. If a design sampled the stream while not ready, or strobed a half-filled nibble, the bus values or the pulse count would drift from the model. If it reversed the dot order, bit 3 and bit 0 would swap. The bench measures the frame period with a rest count below the floor to catch a missing clamp. It also measures the rows between frame markers and the alternation flips, so an off-by-one row counter or a misplaced toggle shows up as a wrong period or a missed flip.

// File: rtl/lcd_scan_pkg.sv
`timescale 1ns/1ps
package lcd_scan_pkg;
    // Controller phases: gather four beats, present data, strobe, latch row, rest.
    typedef enum logic [2:0] {
        PH_GATHER,
        PH_SETUP,
        PH_STROBE,
        PH_LATCH,
        PH_REST
    } phase_e;
endpackage

// File: rtl/lcd_nibble_packer.sv
`timescale 1ns/1ps
module lcd_nibble_packer #(
    parameter int BUS_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_en,
    input  logic             load_en,
    input  logic             bit_in,
    output logic [BUS_W-1:0] bus_o
);
    typedef struct packed {
        logic [BUS_W-2:0] acc;
        logic [BUS_W-1:0] bus;
    } pack_t;

    pack_t p_d, p_q;

    always_comb begin
        p_d = p_q;
        if (shift_en) begin
            p_d.acc = {p_q.acc[BUS_W-3:0], bit_in};
        end
        // the first dot shifted in ends up at the top bit
        if (load_en) begin
            p_d.bus = {p_q.acc, bit_in};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    assign bus_o = p_q.bus;
endmodule

// File: rtl/lcd_row_sequencer.sv
`timescale 1ns/1ps
module lcd_row_sequencer #(
    parameter int ROWS = 240
) (
    input  logic clk,
    input  logic rst_n,
    input  logic row_done,
    output logic scan_start_o,
    output logic alt_o
);
    localparam int RW = $clog2(ROWS);
    localparam logic [RW-1:0] LAST_ROW = RW'(ROWS - 1);

    typedef struct packed {
        logic [RW-1:0] row;
        logic          alt;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (row_done) begin
            if (s_q.row == LAST_ROW) begin
                s_d.row = '0;
                s_d.alt = ~s_q.alt;
            end else begin
                s_d.row = s_q.row + RW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign scan_start_o = (s_q.row == '0);
    assign alt_o        = s_q.alt;
endmodule

// File: rtl/lcd_dual_scan_ctrl.sv
`timescale 1ns/1ps
module lcd_dual_scan_ctrl #(
    parameter int COLS     = 640,
    parameter int ROWS     = 240,
    parameter int BUS_W    = 4,
    parameter int IDLE_W   = 14,
    parameter int MIN_IDLE = 5706
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDLE_W-1:0] idle_cycles,
    input  logic              pix_valid,
    input  logic              pix_upper,
    input  logic              pix_lower,
    output logic              pix_ready,
    output logic [BUS_W-1:0]  lcd_du,
    output logic [BUS_W-1:0]  lcd_dl,
    output logic              lcd_cp2,
    output logic              lcd_cp1,
    output logic              lcd_s,
    output logic              lcd_m
);
    import lcd_scan_pkg::*;

    localparam int NIBS = COLS / BUS_W;
    localparam int BW   = $clog2(BUS_W);
    localparam int NW   = $clog2(NIBS);
    localparam logic [IDLE_W-1:0] FLOOR    = IDLE_W'(MIN_IDLE);
    localparam logic [BW-1:0]     LAST_BIT = BW'(BUS_W - 1);
    localparam logic [NW-1:0]     LAST_NIB = NW'(NIBS - 1);

    typedef struct packed {
        phase_e            ph;
        logic [BW-1:0]     bcnt;
        logic [NW-1:0]     ncnt;
        logic [IDLE_W-1:0] rest;
    } ctl_t;

    ctl_t              c_d, c_q;
    logic              shift_en, load_en, row_done;
    logic [IDLE_W-1:0] rest_len;
    logic [BUS_W-1:0]  half_bus [2];

    // the rest count never drops below the frame-rate floor
    assign rest_len = (idle_cycles < FLOOR) ? FLOOR : idle_cycles;

    always_comb begin
        c_d      = c_q;
        shift_en = 1'b0;
        load_en  = 1'b0;
        unique case (c_q.ph)
            PH_GATHER: begin
                if (pix_valid) begin
                    shift_en = 1'b1;
                    if (c_q.bcnt == LAST_BIT) begin
                        load_en  = 1'b1;
                        c_d.bcnt = '0;
                        c_d.ph   = PH_SETUP;
                    end else begin
                        c_d.bcnt = c_q.bcnt + BW'(1);
                    end
                end
            end
            PH_SETUP: c_d.ph = PH_STROBE;
            PH_STROBE: begin
                if (c_q.ncnt == LAST_NIB) begin
                    c_d.ncnt = '0;
                    c_d.ph   = PH_LATCH;
                end else begin
                    c_d.ncnt = c_q.ncnt + NW'(1);
                    c_d.ph   = PH_GATHER;
                end
            end
            PH_LATCH: begin
                if (rest_len == '0) begin
                    c_d.ph = PH_GATHER;
                end else begin
                    c_d.rest = rest_len;
                    c_d.ph   = PH_REST;
                end
            end
            PH_REST: begin
                if (c_q.rest <= IDLE_W'(1)) begin
                    c_d.rest = '0;
                    c_d.ph   = PH_GATHER;
                end else begin
                    c_d.rest = c_q.rest - IDLE_W'(1);
                end
            end
            default: c_d.ph = PH_GATHER;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '{ph: PH_GATHER, bcnt: '0, ncnt: '0, rest: '0};
        else        c_q <= c_d;
    end

    for (genvar h = 0; h < 2; h++) begin : g_half
        lcd_nibble_packer #(.BUS_W(BUS_W)) i_pack (
            .clk      (clk),
            .rst_n    (rst_n),
            .shift_en (shift_en),
            .load_en  (load_en),
            .bit_in   ((h == 0) ? pix_upper : pix_lower),
            .bus_o    (half_bus[h])
        );
    end

    assign row_done = (c_q.ph == PH_LATCH);

    lcd_row_sequencer #(.ROWS(ROWS)) i_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .row_done     (row_done),
        .scan_start_o (lcd_s),
        .alt_o        (lcd_m)
    );

    assign pix_ready = (c_q.ph == PH_GATHER);
    assign lcd_cp2   = (c_q.ph == PH_STROBE);
    assign lcd_cp1   = row_done;
    assign lcd_du    = half_bus[0];
    assign lcd_dl    = half_bus[1];
endmodule

// File: rtl/lcd_scan_checker.sv
`timescale 1ns/1ps
module lcd_scan_checker #(
    parameter int BUS_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pix_ready,
    input logic [BUS_W-1:0] lcd_du,
    input logic [BUS_W-1:0] lcd_dl,
    input logic             lcd_cp2,
    input logic             lcd_cp1,
    input logic             lcd_s,
    input logic             lcd_m
);
    // R3
    cp2_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lcd_cp2 |=> !lcd_cp2);

    // R5
    cp1_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lcd_cp1 |=> !lcd_cp1);

    // R5
    cp1_after_cp2_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lcd_cp1 |-> $past(lcd_cp2) && !lcd_cp2);

    // R4
    bus_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lcd_cp2 |-> $stable(lcd_du) && $stable(lcd_dl));

    // R4
    bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lcd_cp2 |=> $stable(lcd_du) && $stable(lcd_dl));

    // R6
    ready_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pix_ready |-> !lcd_cp2 && !lcd_cp1);

    // R9
    alt_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(lcd_m) |-> $past(lcd_cp1));

    // R8
    scan_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(lcd_s) |-> $past(lcd_cp1));
endmodule

bind lcd_dual_scan_ctrl lcd_scan_checker #(.BUS_W(BUS_W)) i_scan_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pix_ready (pix_ready),
    .lcd_du    (lcd_du),
    .lcd_dl    (lcd_dl),
    .lcd_cp2   (lcd_cp2),
    .lcd_cp1   (lcd_cp1),
    .lcd_s     (lcd_s),
    .lcd_m     (lcd_m)
);

// File: tb/test_lcd_dual_scan_ctrl.sv
`timescale 1ns/1ps
module test_lcd_dual_scan_ctrl;
    localparam int COLS     = 16;
    localparam int ROWS     = 4;
    localparam int BUS_W    = 4;
    localparam int IDLE_W   = 8;
    localparam int MIN_IDLE = 2;
    localparam int NIBS     = COLS / BUS_W;
    localparam int ROW_BASE = NIBS * (BUS_W + 2) + 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [IDLE_W-1:0] idle_cycles = 8'd3;
    logic              pix_valid = 1'b0;
    logic              pix_upper = 1'b0;
    logic              pix_lower = 1'b0;
    logic              pix_ready;
    logic [BUS_W-1:0]  lcd_du, lcd_dl;
    logic              lcd_cp2, lcd_cp1, lcd_s, lcd_m;

    always #2.5 clk = ~clk;

    lcd_dual_scan_ctrl #(
        .COLS(COLS), .ROWS(ROWS), .BUS_W(BUS_W), .IDLE_W(IDLE_W), .MIN_IDLE(MIN_IDLE)
    ) i_lcd_dual_scan_ctrl (
        .clk(clk), .rst_n(rst_n), .idle_cycles(idle_cycles),
        .pix_valid(pix_valid), .pix_upper(pix_upper), .pix_lower(pix_lower),
        .pix_ready(pix_ready), .lcd_du(lcd_du), .lcd_dl(lcd_dl),
        .lcd_cp2(lcd_cp2), .lcd_cp1(lcd_cp1), .lcd_s(lcd_s), .lcd_m(lcd_m)
    );

    int checks = 0;
    int failures = 0;
    int cyc = 0;

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // ---------------- stimulus driver ----------------
    int stall_pct = 0;
    always @(posedge clk) begin
        #1;
        pix_upper <= 1'($urandom);
        pix_lower <= 1'($urandom);
        pix_valid <= (stall_pct == 0) ? 1'b1 : (($urandom % 100) >= stall_pct);
    end

    // ---------------- reference model ----------------
    int m_ph;            // 0 gather, 1 setup, 2 strobe, 3 latch, 4 rest
    int uq[$];
    int lq[$];
    int m_nib, m_row, m_rest, m_du, m_dl;
    bit m_alt;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_ph = 0; m_nib = 0; m_row = 0; m_rest = 0;
            m_du = 0; m_dl = 0; m_alt = 1'b0;
            uq.delete(); lq.delete();
        end else begin
            case (m_ph)
                0: if (pix_valid) begin
                    uq.push_back(int'(pix_upper));
                    lq.push_back(int'(pix_lower));
                    if (uq.size() == BUS_W) begin
                        m_du = 0; m_dl = 0;
                        foreach (uq[i]) begin
                            m_du = m_du * 2 + uq[i];
                            m_dl = m_dl * 2 + lq[i];
                        end
                        uq.delete(); lq.delete();
                        m_ph = 1;
                    end
                end
                1: m_ph = 2;
                2: begin
                    m_nib++;
                    if (m_nib == NIBS) begin m_nib = 0; m_ph = 3; end
                    else m_ph = 0;
                end
                3: begin
                    m_row++;
                    if (m_row == ROWS) begin m_row = 0; m_alt = ~m_alt; end
                    m_rest = (int'(idle_cycles) < MIN_IDLE) ? MIN_IDLE : int'(idle_cycles);
                    m_ph = (m_rest > 0) ? 4 : 0;
                end
                default: begin
                    m_rest--;
                    if (m_rest == 0) m_ph = 0;
                end
            endcase
        end
    end

    // ---------------- per-clock comparison and monitors ----------------
    int cp2_in_row = 0, rows_in_frame = 0, s_rises = 0, last_rise = 0, period = 0;
    int gap = 0, gap_exp = 0;
    bit gap_on = 1'b0, s_prev = 1'b1, cp2_prev = 1'b0;
    logic [BUS_W-1:0] du_prev = '0, dl_prev = '0, du_strobe = '0;

    always @(negedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            failures++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
        if (rst_n) begin
            chk("R6", "ready", int'(pix_ready), int'(m_ph == 0));
            chk("R3", "cp2", int'(lcd_cp2), int'(m_ph == 2));
            chk("R5", "cp1", int'(lcd_cp1), int'(m_ph == 3));
            chk("R2", "upper bus", int'(lcd_du), m_du);
            chk("R2", "lower bus", int'(lcd_dl), m_dl);
            chk("R8", "frame marker", int'(lcd_s), int'(m_row == 0));
            chk("R9", "alternation", int'(lcd_m), int'(m_alt));
            // R4: bus value around the strobe
            if (lcd_cp2) begin
                chk("R4", "upper bus before strobe", int'(lcd_du), int'(du_prev));
                chk("R4", "lower bus before strobe", int'(lcd_dl), int'(dl_prev));
                du_strobe = lcd_du;
            end
            if (cp2_prev) chk("R4", "upper bus after strobe", int'(lcd_du), int'(du_strobe));
            // R3: pulses per row
            if (lcd_cp2) cp2_in_row++;
            if (lcd_cp1) begin
                chk("R3", "strobes per row", cp2_in_row, NIBS);
                cp2_in_row = 0;
                rows_in_frame++;
            end
            // R7: rest length after the latch
            if (gap_on) begin
                if (!pix_ready) gap++;
                else begin
                    chk("R7", "rest clocks", gap, gap_exp);
                    gap_on = 1'b0;
                end
            end
            if (lcd_cp1) begin
                gap_on = 1'b1; gap = 0;
                gap_exp = (int'(idle_cycles) < MIN_IDLE) ? MIN_IDLE : int'(idle_cycles);
            end
            // R8: rows between frame markers
            if (lcd_s && !s_prev) begin
                chk("R8", "rows per frame", rows_in_frame, ROWS);
                rows_in_frame = 0;
                period = cyc - last_rise;
                last_rise = cyc;
                s_rises++;
            end
        end
        s_prev = lcd_s; cp2_prev = lcd_cp2; du_prev = lcd_du; dl_prev = lcd_dl;
    end

    task automatic wait_rise();
        int n = s_rises;
        while (s_rises == n) @(negedge clk);
    endtask

    // ---------------- sequence ----------------
    initial begin
        bit m_seen;
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        chk("R1", "cp2 in reset", int'(lcd_cp2), 0);
        chk("R1", "cp1 in reset", int'(lcd_cp1), 0);
        chk("R1", "upper bus in reset", int'(lcd_du), 0);
        chk("R1", "lower bus in reset", int'(lcd_dl), 0);
        chk("R1", "marker in reset", int'(lcd_s), 1);
        chk("R1", "alternation in reset", int'(lcd_m), 0);
        chk("R1", "ready in reset", int'(pix_ready), 1);
        rst_n = 1'b1;

        // R10: full-rate stream, rest 3
        stall_pct = 0; idle_cycles = 8'd3;
        wait_rise();
        m_seen = lcd_m;
        wait_rise();
        chk("R10", "frame period at full rate", period, ROWS * (ROW_BASE + 3));
        chk("R9", "alternation flipped over a frame", int'(lcd_m), int'(!m_seen));

        // R6: random stalls, rest 5
        @(posedge clk); #1;
        stall_pct = 40; idle_cycles = 8'd5;
        repeat (800) @(posedge clk);
        // R6: long stall, nothing must be strobed beyond the model
        #1 stall_pct = 100;
        repeat (40) @(posedge clk);
        #1 stall_pct = 0;

        // R7: rest below the floor is clamped
        @(posedge clk); #1;
        idle_cycles = 8'd0;
        wait_rise();
        m_seen = lcd_m;
        wait_rise();
        chk("R7", "frame period with clamped rest", period, ROWS * (ROW_BASE + MIN_IDLE));
        chk("R9", "alternation flipped again", int'(lcd_m), int'(!m_seen));

        // R10: keeps refreshing with a longer rest
        @(posedge clk); #1;
        idle_cycles = 8'd9;
        wait_rise();
        wait_rise();
        chk("R10", "frame period with rest 9", period, ROWS * (ROW_BASE + 9));

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule